// File: doc/BRIEF.md
# Sample Timing and Gate Sequencer

This block sets the timing for a multi-channel charge integrator. It divides the system clock into a programmable sample period and issues a one-cycle conversion strobe to the ADC once per period. It takes a gate either from an external input or from an internal test generator. A fixed settle time plus a programmable number of sample periods after the gate's rising edge, it issues a one-cycle trigger to the integration logic. That trigger always falls on a conversion strobe. The integration logic answers with a one-cycle `integ_done` pulse, and the sequencer then accepts the next gate.

Three conversion modes control how the strobe relates to the gate. In gated mode the strobe runs only while a gate sequence is active. In free-running mode the strobe never stops and ignores gates. In re-phasing mode the strobe runs all the time, but its phase restarts on every accepted gate. This keeps several modules in step.

The controller is a four-state machine:
- **IDLE** goes to **SETTLE** on an accepted gate edge (the *accept* transition).
- **SETTLE** goes to **WAIT** after `SETTLE_CLKS` clocks (the *settled* transition).
- **WAIT** goes to **INTEG** on the strobe that completes the programmed delay (the *fire* transition, which raises `trig`).
- **INTEG** goes back to **IDLE** on `integ_done` (the *release* transition).

Top module: `sample_gate_seq`

## Requirements
- R1: While the strobe is running, `conv_strobe` pulses high for one cycle every `period_mult + 40` clocks. `period_mult` is unsigned, 0 to 255.
- R2: With `conv_mode` = 0 (gated), there is no strobe while the state is IDLE. After a gate is accepted in cycle g, the first strobe is in cycle g + P, where P = `period_mult + 40`. Strobes continue until the release transition.
- R3: With `conv_mode` = 1 (free-running), strobes fall in the cycles n where (n+1) mod P = 0, counting cycle 0 as the first cycle after reset. Gates never move them.
- R4: With `conv_mode` = 2 or 3 (re-phasing), an accepted gate in cycle g restarts the phase. The next strobe is in cycle g + P and every P cycles after that.
- R5: After a gate is accepted in cycle g, cycles g+1 to g+`SETTLE_CLKS` (default 50) form the settle time. `trig` is then high for exactly one cycle, on the (`gate_delay`+1)-th strobe that falls after cycle g+`SETTLE_CLKS`, and it coincides with that strobe.
- R6: `gate_sel` = 0 selects the internal gate and `gate_sel` = 1 selects the external gate. The unselected source has no effect.
- R7: The internal gate is a one-cycle event every 200 × `int_div` clocks (`int_div` = 0 acts as 1). The first event is in cycle 200 × `int_div` − 1 after reset.
- R8: The external gate acts only on its rising edge, after a two-stage synchroniser. A level sampled high at clock edge k after a low at edge k−1 gives a gate event in cycle k+1. A held-high level gives no further events.
- R9: A gate event in any state other than IDLE is dropped and sets `overrun`. `overrun` stays set until reset.
- R10: `integ_done` returns the sequencer from INTEG to IDLE. In any other state it has no effect.
- R11: During and right after reset, `conv_strobe`, `trig` and `overrun` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_mult | input | 8 | Sample period extension beyond the 40-clock base |
| gate_delay | input | 8 | Number of sample periods between settle end and trigger |
| gate_sel | input | 1 | Gate source: 0 internal, 1 external |
| int_div | input | 16 | Internal gate divider applied to the 200-clock reference |
| conv_mode | input | 2 | 0 gated, 1 free-running, 2 or 3 re-phasing |
| ext_gate | input | 1 | Asynchronous external gate level |
| integ_done | input | 1 | One-cycle pulse from the integration logic ending the sequence |
| conv_strobe | output | 1 | One-cycle ADC conversion strobe |
| trig | output | 1 | One-cycle start-of-integration trigger |
| overrun | output | 1 | Sticky flag: a gate arrived while busy |

## Verification
The hardest cases are a gate that arrives while the sequencer is in WAIT, and a gate that re-phases the strobe partway through a long period. The stimulus reaches the first by sending a second external edge about a hundred cycles after the first one, before the third counted strobe has fired. It reaches the second by placing gates at cycle offsets that are not multiples of the period, with the longest period selected. A behavioural model predicts the strobe from modular arithmetic on the cycle count and a phase origin. It is compared with all three outputs on every clock, including the stretches where the unselected source toggles or the external level is held high.

// File: rtl/sgs_pkg.sv
package sgs_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SETTLE = 2'd1,
        S_WAIT   = 2'd2,
        S_INTEG  = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        CM_GATED       = 2'd0,
        CM_FREE        = 2'd1,
        CM_REPHASE     = 2'd2,
        CM_REPHASE_ALT = 2'd3
    } conv_mode_t;

endpackage

// File: rtl/sgs_gate_front.sv
module sgs_gate_front #(
    parameter int DIV_W   = 16,
    parameter int REF_DIV = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_gate,
    input  logic             gate_sel,
    input  logic [DIV_W-1:0] int_div,
    output logic             gate_ev
);
    localparam int PRE_W = $clog2(REF_DIV);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(REF_DIV - 1);

    // external path: two synchroniser stages plus an edge register
    logic [2:0] sync_q;
    logic       ext_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], ext_gate};
    end

    assign ext_rise = sync_q[1] & ~sync_q[2];

    // internal path: fixed reference prescaler, then programmable divider
    logic [PRE_W-1:0] pre_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_eff;
    logic             ref_tick;
    logic             int_pulse;

    assign div_eff   = (int_div == '0) ? DIV_W'(1) : int_div;
    assign ref_tick  = (pre_q == PRE_LAST);
    assign int_pulse = ref_tick && (div_q >= div_eff - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            div_q <= '0;
        end else begin
            pre_q <= ref_tick ? '0 : pre_q + PRE_W'(1);
            if (ref_tick) div_q <= int_pulse ? '0 : div_q + DIV_W'(1);
        end
    end

    assign gate_ev = gate_sel ? ext_rise : int_pulse;

    AST_EXT_EDGE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rise |=> !ext_rise); // R8
    AST_INT_GATE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        int_pulse |=> !int_pulse); // R7

endmodule

// File: rtl/sgs_phase_gen.sv
module sgs_phase_gen #(
    parameter int MULT_W        = 8,
    parameter int PERIOD_OFFSET = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MULT_W-1:0] period_mult,
    input  logic              hold,
    input  logic              restart,
    output logic              strobe
);
    localparam int PH_W = $clog2((1 << MULT_W) + PERIOD_OFFSET);
    localparam logic [PH_W-1:0] OFF_V = PH_W'(PERIOD_OFFSET);

    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] phase_last;

    assign phase_last = PH_W'(period_mult) + OFF_V - PH_W'(1);
    assign strobe     = !hold && (phase_q >= phase_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 phase_q <= '0;
        else if (hold || restart)   phase_q <= '0;
        else if (strobe)            phase_q <= '0;
        else                        phase_q <= phase_q + PH_W'(1);
    end

    AST_STROBE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe); // R1

endmodule

// File: rtl/sample_gate_seq.sv
module sample_gate_seq #(
    parameter int MULT_W        = 8,
    parameter int PERIOD_OFFSET = 40,
    parameter int DLY_W         = 8,
    parameter int DIV_W         = 16,
    parameter int REF_DIV       = 200,
    parameter int SETTLE_CLKS   = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MULT_W-1:0] period_mult,
    input  logic [DLY_W-1:0]  gate_delay,
    input  logic              gate_sel,
    input  logic [DIV_W-1:0]  int_div,
    input  logic [1:0]        conv_mode,
    input  logic              ext_gate,
    input  logic              integ_done,
    output logic              conv_strobe,
    output logic              trig,
    output logic              overrun
);
    import sgs_pkg::*;

    localparam int SC_W = $clog2(SETTLE_CLKS + 1);
    localparam logic [SC_W-1:0] SETTLE_LAST = SC_W'(SETTLE_CLKS - 1);

    seq_state_t       state, nxt;
    conv_mode_t       mode;
    logic             gate_ev;
    logic             strobe;
    logic             hold;
    logic             restart;
    logic [SC_W-1:0]  settle_cnt;
    logic [DLY_W-1:0] strobe_cnt;
    logic             overrun_q;

    assign mode    = conv_mode_t'(conv_mode);
    assign hold    = (mode == CM_GATED) && (state == S_IDLE);
    assign restart = gate_ev && (state == S_IDLE) && (mode != CM_FREE);

    sgs_gate_front #(.DIV_W(DIV_W), .REF_DIV(REF_DIV)) u_gate_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_gate (ext_gate),
        .gate_sel (gate_sel),
        .int_div  (int_div),
        .gate_ev  (gate_ev)
    );

    sgs_phase_gen #(.MULT_W(MULT_W), .PERIOD_OFFSET(PERIOD_OFFSET)) u_phase_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_mult (period_mult),
        .hold        (hold),
        .restart     (restart),
        .strobe      (strobe)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // transitions: accept, settled, fire, release
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (gate_ev) nxt = S_SETTLE;
            S_SETTLE: if (settle_cnt == SETTLE_LAST) nxt = S_WAIT;
            S_WAIT:   if (strobe && (strobe_cnt == gate_delay)) nxt = S_INTEG;
            S_INTEG:  if (integ_done) nxt = S_IDLE;
        endcase
    end

    // per-state counters and sticky overrun
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_cnt <= '0;
            strobe_cnt <= '0;
            overrun_q  <= 1'b0;
        end else begin
            settle_cnt <= (state == S_SETTLE) ? settle_cnt + SC_W'(1) : '0;
            if (state != S_WAIT) strobe_cnt <= '0;
            else if (strobe)     strobe_cnt <= strobe_cnt + DLY_W'(1);
            if (gate_ev && (state != S_IDLE)) overrun_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        conv_strobe = strobe;
        trig        = (state == S_WAIT) && strobe && (strobe_cnt == gate_delay);
        overrun     = overrun_q;
    end

    AST_TRIG_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> conv_strobe); // R5
    AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig); // R5
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R9
    AST_BUSY_GATE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_ev && state == S_WAIT) |=> (state != S_SETTLE)); // R9
    AST_DONE_IGNORED_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && !strobe) |=> (state == S_WAIT)); // R10

endmodule

// File: tb/sample_gate_seq_bench.sv
module sample_gate_seq_bench;
    localparam int SETTLE = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  period_mult = '0;
    logic [7:0]  gate_delay = '0;
    logic        gate_sel = 1'b1;
    logic [15:0] int_div = 16'd1;
    logic [1:0]  conv_mode = 2'd1;
    logic        ext_gate = 1'b0;
    logic        integ_done = 1'b0;
    logic        conv_strobe, trig, overrun;

    always #10 clk = ~clk;

    sample_gate_seq u_sample_gate_seq (
        .clk(clk), .rst_n(rst_n), .period_mult(period_mult), .gate_delay(gate_delay),
        .gate_sel(gate_sel), .int_div(int_div), .conv_mode(conv_mode), .ext_gate(ext_gate),
        .integ_done(integ_done), .conv_strobe(conv_strobe), .trig(trig), .overrun(overrun)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R11";
    bit    chk_en = 0;
    int    trig_seen = 0;
    int    strobe_seen = 0;
    int    integ_len = 0;
    bit    stray_req = 0;
    int    done_cnt = 0;

    task automatic check(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_cyc, m_st, m_cnt, m_ovr, m_org, m_sett;
    bit h0, h1, h2;

    function automatic bit exp_gate();
        int n;
        int d;
        if (gate_sel) return h1 && !h2;
        d = (int_div == 0) ? 1 : int'(int_div);
        n = m_cyc - 199;
        if (n < 0 || (n % 200) != 0) return 0;
        return ((n / 200) % d) == d - 1;
    endfunction

    function automatic bit exp_strobe();
        int p;
        p = int'(period_mult) + 40;
        if (conv_mode == 2'd0 && m_st == 0) return 0;
        return ((m_cyc - m_org) % p) == p - 1;
    endfunction

    function automatic bit exp_trig();
        return m_st == 2 && exp_strobe() && m_cnt == int'(gate_delay);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cyc = 0; m_st = 0; m_cnt = 0; m_ovr = 0; m_org = 0; m_sett = 0;
            h0 = 0; h1 = 0; h2 = 0;
        end else begin
            bit ge, sb, tr;
            ge = exp_gate(); sb = exp_strobe(); tr = exp_trig();
            if (ge && m_st != 0) m_ovr = 1;
            case (m_st)
                0: if (ge) begin
                       m_st = 1;
                       m_sett = m_cyc + SETTLE;
                       if (conv_mode != 2'd1) m_org = m_cyc + 1;
                   end
                1: if (m_cyc == m_sett) begin m_st = 2; m_cnt = 0; end
                2: if (sb) begin if (tr) m_st = 3; else m_cnt++; end
                3: if (integ_done) m_st = 0;
                default: m_st = 0;
            endcase
            m_cyc++;
            h2 = h1; h1 = h0; h0 = ext_gate;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (chk_en) begin
            check(cur_req, "conv_strobe", int'(conv_strobe), int'(exp_strobe()));
            check(cur_req, "trig", int'(trig), int'(exp_trig()));
            check(cur_req, "overrun", int'(overrun), m_ovr);
            if (trig) trig_seen++;
            if (conv_strobe) strobe_seen++;
        end
    end

    // integration-logic stand-in
    always @(negedge clk) begin
        if (!rst_n) begin
            done_cnt = 0;
            integ_done = 1'b0;
        end else begin
            integ_done = 1'b0;
            if (stray_req) begin integ_done = 1'b1; stray_req = 0; end
            if (done_cnt > 0) begin
                done_cnt--;
                if (done_cnt == 0) integ_done = 1'b1;
            end
            if (trig && integ_len > 0) done_cnt = integ_len;
        end
    end

    task automatic do_reset(input int mode, input int mult, input int gd, input int sel,
                            input int div, input int ilen);
        @(negedge clk);
        chk_en = 0;
        rst_n = 1'b0;
        ext_gate = 1'b0;
        conv_mode = 2'(mode); period_mult = 8'(mult); gate_delay = 8'(gd);
        gate_sel = 1'(sel); int_div = 16'(div); integ_len = ilen;
        repeat (3) @(negedge clk);
        check("R11", "strobe in reset", int'(conv_strobe), 0);
        check("R11", "trig in reset", int'(trig), 0);
        check("R11", "overrun in reset", int'(overrun), 0);
        rst_n = 1'b1;
        @(posedge clk);
        trig_seen = 0;
        strobe_seen = 0;
        chk_en = 1;
    endtask

    task automatic ext_pulse(input int width);
        @(negedge clk);
        ext_gate = 1'b1;
        repeat (width) @(negedge clk);
        ext_gate = 1'b0;
    endtask

    task automatic measure_period(output int d);
        d = 0;
        do @(negedge clk); while (!conv_strobe);
        do begin @(negedge clk); d++; end while (!conv_strobe);
    endtask

    initial begin
        int d;
        // free-running, busy-gate overrun
        do_reset(1, 0, 2, 1, 1, 200);
        cur_req = "R1";
        measure_period(d);
        check("R1", "strobe spacing P=40", d, 40);
        cur_req = "R3";
        ext_pulse(3);
        repeat (100) @(negedge clk);
        cur_req = "R9";
        ext_pulse(3);
        repeat (400) @(negedge clk);
        check("R9", "overrun set by busy gate", int'(overrun), 1);
        check("R5", "trigger count free mode", trig_seen, 1);

        // gated mode, stray done
        do_reset(0, 10, 0, 1, 1, 150);
        cur_req = "R2";
        repeat (120) @(negedge clk);
        check("R2", "no strobe while idle", strobe_seen, 0);
        cur_req = "R10";
        stray_req = 1;
        repeat (20) @(negedge clk);
        ext_pulse(2);
        repeat (400) @(negedge clk);
        check("R10", "trigger after stray done", trig_seen, 1);
        strobe_seen = 0;
        cur_req = "R2";
        repeat (300) @(negedge clk);
        check("R2", "strobes stop after release", strobe_seen, 0);
        ext_pulse(2);
        repeat (400) @(negedge clk);
        check("R10", "second sequence after release", trig_seen, 2);
        check("R9", "no overrun when idle", int'(overrun), 0);

        // re-phasing, longest period
        do_reset(2, 255, 1, 1, 1, 100);
        cur_req = "R4";
        repeat (137) @(negedge clk);
        ext_pulse(2);
        repeat (800) @(negedge clk);
        ext_pulse(2);
        repeat (800) @(negedge clk);
        check("R4", "trigger count mode 2", trig_seen, 2);
        do_reset(3, 255, 0, 1, 1, 100);
        cur_req = "R4";
        repeat (61) @(negedge clk);
        ext_pulse(2);
        repeat (700) @(negedge clk);
        check("R4", "trigger count mode 3", trig_seen, 1);

        // internal gate, external toggling ignored
        do_reset(1, 20, 0, 0, 2, 100);
        cur_req = "R7";
        for (int i = 0; i < 9; i++) begin
            repeat (150) @(negedge clk);
            ext_pulse(2);
        end
        check("R7", "internal gate triggers", trig_seen, 3);
        check("R6", "external edges ignored", int'(overrun), 0);

        // held external level
        do_reset(1, 0, 0, 1, 1, 60);
        cur_req = "R8";
        repeat (10) @(negedge clk);
        ext_gate = 1'b1;
        repeat (500) @(negedge clk);
        check("R8", "held level single trigger", trig_seen, 1);
        ext_gate = 1'b0;
        repeat (5) @(negedge clk);
        ext_gate = 1'b1;
        repeat (300) @(negedge clk);
        check("R8", "new rising edge retriggers", trig_seen, 2);
        check("R8", "no overrun from level", int'(overrun), 0);

        chk_en = 0;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule